// File: doc/BRIEF.md
# SMBus Block-Write Configuration Register Slave

This block is an SMBus target that accepts only block-write transfers and uses them to load a small bank of eight-bit configuration registers. The registers drive the clock-control logic around it. It samples the open-drain SCL and SDA lines with the system clock through synchronizers. It recognises START and STOP as SDA edges while SCL is high. Acknowledge is sent by asserting `sda_pull`, which the pad turns into a low on SDA.

A transfer consists of the following bytes, each followed by an acknowledge bit:

1. The write address 0xD2.
2. A command byte, which must be zero.
3. A count byte from 1 to `MAX_COUNT`.
4. The data bytes. These land in register 0, then register 1, and so on upward.

The master may stop after any whole byte. Nothing can reach a register until the count byte has been accepted. Some register bits are read-only. Byte 0 carries three strap pins latched during reset and the live level of an external stop pin. Byte 6 is a fixed identification value.

The controller has seven states:

- `ST_IDLE`: waits for a START.
- `ST_ADDR`, `ST_CMD`, `ST_COUNT`, `ST_DATA`: each shifts in one byte on SCL rising edges.
- `ST_WAIT_ACK`: waits for the falling SCL edge that ends the eighth bit.
- `ST_ACK`: pulls SDA for the ninth clock.

The transitions are:

- A START from any state moves to `ST_ADDR`. A STOP from any state moves to `ST_IDLE`.
- In a receive state, a completed byte moves to `ST_WAIT_ACK` if the byte is accepted, or to `ST_IDLE` if it is refused (a NACK).
- `ST_WAIT_ACK` moves to `ST_ACK` on a falling SCL edge.
- `ST_ACK` moves on the next falling SCL edge to the following receive state. Those are `ST_CMD` after the address, `ST_COUNT` after the command, and `ST_DATA` after the count or a data byte.

Top module: `cfg_smbus_slave`

## Requirements
- R1: After reset, `cfg_out` bytes 1 to 6 read 0x07, 0x7F, 0xC7, 0x3F, 0x00, 0x08. In byte 0, bits 7, 6, 5 and 3 read 0. Byte i sits at `cfg_out[8*i+7:8*i]`.
- R2: Byte 0 bits 2..0 return `strap_in` as held during reset, and later changes of `strap_in` do not alter them. Byte 0 bit 4 follows `cpu_stop_in` at all times.
- R3: The address byte 0xD2 (address 0x69, write) is acknowledged. Any other address byte, including the read form 0xD3, is not acknowledged. The slave then ignores the bus until the next START.
- R4: A command byte of 0x00 is acknowledged. Any other value is not acknowledged and leaves every register unchanged.
- R5: A count byte from 1 to 32 is acknowledged. A count of 0 or above 32 is not acknowledged and leaves every register unchanged.
- R6: Data bytes, MSB first, are each acknowledged and written to registers 0, 1, 2 and upward in order.
- R7: Writes change only the writable bits. Per byte 0..6 those are masks 0xA8, 0x7F, 0x7F, 0xFF, 0x3F, 0x3F and 0x00. All other bits keep their read-only value.
- R8: A STOP after any complete data byte ends the transfer. The registers already written keep their new values and the later ones keep their old values.
- R9: Data bytes beyond the declared count, or beyond register 6, are acknowledged but discarded.
- R10: A repeated START or a STOP in the middle of a byte aborts the transfer without committing the partial byte. A following transfer works normally.
- R11: During an acknowledge, `sda_pull` is high while SCL is high on the ninth clock and is low again after that clock's falling edge. `sda_pull` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset; straps are captured while it is low |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level (wired-AND of master and slave) |
| sda_pull | output | 1 | 1 = drive SDA low (acknowledge) |
| strap_in | input | 3 | Strap pins latched during reset into byte 0 bits 2..0 |
| cpu_stop_in | input | 1 | Live stop-pin level shown in byte 0 bit 4 |
| cfg_out | output | 56 | Register bank, byte i at bits 8*i+7..8*i |

## Verification
The assertions assume that the master changes SDA only while SCL is low, except for START and STOP. They also assume that every SCL high and low phase lasts several system clocks longer than the two-stage synchronizer latency. Under these conditions the acknowledge pull can never start or end while SCL is high. The bench master keeps every SCL phase at eight system clocks and moves SDA only in the low phase. It models the line as a wired-AND of its own drive and `sda_pull`. A START or STOP is formed only by raising SCL first and then moving SDA.

// File: rtl/cfgsm_pkg.sv
package cfgsm_pkg;

    localparam int NREG = 7;
    localparam int IDXW = $clog2(NREG);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_COUNT,
        ST_DATA,
        ST_WAIT_ACK,
        ST_ACK
    } sm_state_t;

    // Entry [i] belongs to register byte i.
    localparam logic [NREG-1:0][7:0] WR_MASK =
        {8'h00, 8'h3F, 8'h3F, 8'hFF, 8'h7F, 8'h7F, 8'hA8};
    localparam logic [NREG-1:0][7:0] PWR_DEF =
        {8'h00, 8'h00, 8'h3F, 8'hC7, 8'h7F, 8'h07, 8'h00};
    localparam logic [NREG-1:0][7:0] RO_FIX =
        {8'h08, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};

    localparam int STOP_BIT = 4;

endpackage

// File: rtl/cfgsm_sync.sv
module cfgsm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int TOP = STAGES - 1;

    logic [TOP:0] scl_ff, sda_ff;
    logic         scl_p, sda_p;

    // Same depth chain for both lines so their samples stay aligned.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[TOP-1:0], scl_in};
            sda_ff <= {sda_ff[TOP-1:0], sda_in};
            scl_p  <= scl_ff[TOP];
            sda_p  <= sda_ff[TOP];
        end
    end

    assign scl_s     = scl_ff[TOP];
    assign sda_s     = sda_ff[TOP];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/cfgsm_fsm.sv
module cfgsm_fsm
    import cfgsm_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR7 = 7'h69,
    parameter int         MAX_COUNT   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_s,
    input  logic            sda_s,
    input  logic            scl_rise,
    input  logic            scl_fall,
    input  logic            start_det,
    input  logic            stop_det,
    output logic            sda_pull,
    output logic            wr_en,
    output logic [IDXW-1:0] wr_idx,
    output logic [7:0]      wr_data
);

    localparam int              CW        = $clog2(MAX_COUNT + 1);
    localparam logic [7:0]      ADDR_BYTE = {SLAVE_ADDR7, 1'b0};
    localparam logic [7:0]      MAXC8     = 8'(MAX_COUNT);
    localparam logic [CW-1:0]   NREG_C    = CW'(NREG);

    sm_state_t       state_q, state_d, resume_q;
    logic [2:0]      bitcnt_q;
    logic [7:0]      shift_q;
    logic [CW-1:0]   cnt_q, idx_q;
    logic [7:0]      new_byte;
    logic            rx_state, byte_done, byte_ok;

    assign new_byte  = {shift_q[6:0], sda_s};
    assign rx_state  = (state_q == ST_ADDR) || (state_q == ST_CMD) ||
                       (state_q == ST_COUNT) || (state_q == ST_DATA);
    assign byte_done = rx_state && scl_rise && (bitcnt_q == 3'd7);

    // Acceptance of the byte that just completed.
    always_comb begin
        unique case (state_q)
            ST_ADDR:  byte_ok = (new_byte == ADDR_BYTE);
            ST_CMD:   byte_ok = (new_byte == 8'h00);
            ST_COUNT: byte_ok = (new_byte != 8'h00) && (new_byte <= MAXC8);
            ST_DATA:  byte_ok = 1'b1;
            default:  byte_ok = 1'b0;
        endcase
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_ADDR, ST_CMD, ST_COUNT, ST_DATA:
                    if (byte_done) state_d = byte_ok ? ST_WAIT_ACK : ST_IDLE;
                ST_WAIT_ACK:
                    if (scl_fall) state_d = ST_ACK;
                ST_ACK:
                    if (scl_fall) state_d = resume_q;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Byte datapath.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt_q <= '0;
            shift_q  <= '0;
            cnt_q    <= '0;
            idx_q    <= '0;
            resume_q <= ST_IDLE;
        end else if (start_det) begin
            bitcnt_q <= '0;
            cnt_q    <= '0;
            idx_q    <= '0;
        end else if (!stop_det) begin
            if (rx_state && scl_rise) begin
                shift_q  <= new_byte;
                bitcnt_q <= bitcnt_q + 3'd1;
            end
            if (byte_done && byte_ok) begin
                unique case (state_q)
                    ST_ADDR:  resume_q <= ST_CMD;
                    ST_CMD:   resume_q <= ST_COUNT;
                    ST_COUNT: begin
                        resume_q <= ST_DATA;
                        cnt_q    <= new_byte[CW-1:0];
                    end
                    ST_DATA: begin
                        resume_q <= ST_DATA;
                        if (idx_q != '1) idx_q <= idx_q + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Outputs.
    always_comb begin
        sda_pull = (state_q == ST_ACK);
        wr_en    = (state_q == ST_DATA) && byte_done && !start_det && !stop_det &&
                   (idx_q < cnt_q) && (idx_q < NREG_C);
        wr_idx   = idx_q[IDXW-1:0];
        wr_data  = new_byte;
    end

    assert_pull_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> !scl_s);

    assert_write_after_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (cnt_q != '0) && (state_q == ST_DATA));

    assert_start_restarts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (state_q == ST_ADDR) && !sda_pull);

    assert_bad_addr_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR && byte_done && new_byte != ADDR_BYTE &&
         !start_det && !stop_det) |=> (state_q == ST_IDLE) && !sda_pull);

endmodule

// File: rtl/cfgsm_bank.sv
module cfgsm_bank
    import cfgsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDXW-1:0]   wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [2:0]        strap_in,
    input  logic              cpu_stop_in,
    output logic [NREG*8-1:0] cfg_out
);

    logic [NREG-1:0][7:0] store_q;
    logic [NREG-1:0][7:0] view;
    logic [2:0]           strap_q;

    // Straps follow the pins only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) strap_q <= strap_in;
    end

    for (genvar i = 0; i < NREG; i++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                store_q[i] <= PWR_DEF[i];
            end else if (wr_en && (wr_idx == IDXW'(i))) begin
                store_q[i] <= (store_q[i] & ~WR_MASK[i]) | (wr_data & WR_MASK[i]);
            end
        end

        if (i == 0) begin : g_live
            always_comb begin
                view[i]           = (store_q[i] & WR_MASK[i]) | RO_FIX[i];
                view[i][2:0]      = strap_q;
                view[i][STOP_BIT] = cpu_stop_in;
            end
        end else begin : g_plain
            assign view[i] = (store_q[i] & WR_MASK[i]) | RO_FIX[i];
        end
    end

    assign cfg_out = view;

    assert_hold_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(store_q));

endmodule

// File: rtl/cfg_smbus_slave.sv
module cfg_smbus_slave
    import cfgsm_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR7 = 7'h69,
    parameter int         MAX_COUNT   = 32,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    input  logic [2:0]        strap_in,
    input  logic              cpu_stop_in,
    output logic [NREG*8-1:0] cfg_out
);

    logic            scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic            wr_en;
    logic [IDXW-1:0] wr_idx;
    logic [7:0]      wr_data;

    cfgsm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    cfgsm_fsm #(.SLAVE_ADDR7(SLAVE_ADDR7), .MAX_COUNT(MAX_COUNT)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_pull  (sda_pull),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    cfgsm_bank u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data),
        .strap_in    (strap_in),
        .cpu_stop_in (cpu_stop_in),
        .cfg_out     (cfg_out)
    );

endmodule

// File: tb/cfg_smbus_slave_test.sv
module cfg_smbus_slave_test;

    localparam int Q = 8;
    localparam int NV = 13;

    // {tag, addr, cmd, count, ndata, seed, step}
    localparam logic [55:0] VEC [0:NV-1] = '{
        {8'd6, 8'hD2, 8'h00, 8'h03, 8'h03, 8'hA5, 8'h25}, // R6 three bytes
        {8'd6, 8'hD2, 8'h00, 8'h07, 8'h07, 8'h3C, 8'h11}, // R6 all registers
        {8'd7, 8'hD2, 8'h00, 8'h07, 8'h07, 8'hFF, 8'h00}, // R7 ones everywhere
        {8'd7, 8'hD2, 8'h00, 8'h07, 8'h07, 8'h00, 8'h00}, // R7 zeros everywhere
        {8'd3, 8'hD4, 8'h00, 8'h02, 8'h02, 8'h11, 8'h01}, // R3 wrong address
        {8'd3, 8'hD3, 8'h00, 8'h02, 8'h02, 8'h11, 8'h01}, // R3 read direction
        {8'd4, 8'hD2, 8'h05, 8'h02, 8'h02, 8'h11, 8'h01}, // R4 bad command
        {8'd5, 8'hD2, 8'h00, 8'h00, 8'h01, 8'h11, 8'h01}, // R5 zero count
        {8'd5, 8'hD2, 8'h00, 8'h21, 8'h02, 8'h11, 8'h01}, // R5 count 33
        {8'd5, 8'hD2, 8'h00, 8'h20, 8'h03, 8'h81, 8'h02}, // R5 count 32
        {8'd9, 8'hD2, 8'h00, 8'h02, 8'h04, 8'h5A, 8'h13}, // R9 past count
        {8'd9, 8'hD2, 8'h00, 8'h0A, 8'h0A, 8'h77, 8'h09}, // R9 past register 6
        {8'd8, 8'hD2, 8'h00, 8'h05, 8'h02, 8'hC3, 8'h10}  // R8 early stop
    };

    localparam logic [6:0][7:0] B_MASK = {8'h00, 8'h3F, 8'h3F, 8'hFF, 8'h7F, 8'h7F, 8'hA8};
    localparam logic [6:0][7:0] B_DEF  = {8'h00, 8'h00, 8'h3F, 8'hC7, 8'h7F, 8'h07, 8'h00};
    localparam logic [6:0][7:0] B_FIX  = {8'h08, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic [2:0]  strap = 3'b101;
    logic [2:0]  strap_lat = 3'b101;
    logic        cpu_stop = 1'b0;
    logic        sda_pull;
    logic [55:0] cfg_out;
    logic        sda_line;
    logic [7:0]  exp_store [0:6];
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    assign sda_line = m_sda & ~sda_pull;

    cfg_smbus_slave uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_in      (m_scl),
        .sda_in      (sda_line),
        .sda_pull    (sda_pull),
        .strap_in    (strap),
        .cpu_stop_in (cpu_stop),
        .cfg_out     (cfg_out)
    );

    always #4 clk = ~clk;

    function automatic string tag_name(logic [7:0] t);
        case (t)
            8'd3:    return "R3";
            8'd4:    return "R4";
            8'd5:    return "R5";
            8'd6:    return "R6";
            8'd7:    return "R7";
            8'd8:    return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [7:0] exp_byte(int i);
        logic [7:0] v;
        v = (exp_store[i] & B_MASK[i]) | B_FIX[i];
        if (i == 0) begin
            v[2:0] = strap_lat;
            v[4]   = cpu_stop;
        end
        return v;
    endfunction

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_regs(string req);
        for (int i = 0; i < 7; i++)
            chk(req, $sformatf("reg%0d", i), cfg_out[8*i +: 8], exp_byte(i));
    endtask

    task automatic model_write(int k, logic [7:0] d);
        exp_store[k] = (exp_store[k] & ~B_MASK[k]) | (d & B_MASK[k]);
    endtask

    task automatic wq(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start;
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(Q);
    endtask

    task automatic send_bits(logic [7:0] b, int nb);
        for (int i = 0; i < nb; i++) begin
            m_sda = b[7-i]; wq(Q);
            m_scl = 1'b1;   wq(Q);
            m_scl = 1'b0;   wq(Q);
        end
    endtask

    // Sends a byte, checks the acknowledge and the release after it.
    task automatic send_chk(logic [7:0] b, logic exp_ack, string req);
        logic ack;
        send_bits(b, 8);
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q/2);
        ack = ~sda_line;
        wq(Q/2);
        m_scl = 1'b0; wq(Q);
        chk(req, $sformatf("ack of %h", b), {7'b0, ack}, {7'b0, exp_ack});
        chk("R11", "pull released after ack clock", {7'b0, sda_pull}, 8'h00);
    endtask

    task automatic run_xfer(logic [55:0] v);
        string      req;
        logic [7:0] addr, cmd, cnt, nd, seed, step, d;
        logic       live;
        {addr, cmd, cnt, nd, seed, step} = v[47:0];
        req = tag_name(v[55:48]);
        bus_start;
        live = (addr == 8'hD2);
        send_chk(addr, live, req);
        live = live && (cmd == 8'h00);
        send_chk(cmd, live, req);
        live = live && (cnt != 8'h00) && (cnt <= 8'd32);
        send_chk(cnt, live, req);
        for (int k = 0; k < int'(nd); k++) begin
            d = seed + 8'(k) * step;
            send_chk(d, live, req);
            if (live && k < int'(cnt) && k < 7) model_write(k, d);
        end
        bus_stop;
        wq(Q);
        check_regs(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog all-requirements actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 7; i++) exp_store[i] = B_DEF[i];
        wq(10);
        rst_n = 1'b1;
        wq(4);

        // R1 defaults, R2 strap capture
        check_regs("R1");
        chk("R11", "pull idle after reset", {7'b0, sda_pull}, 8'h00);
        strap = 3'b010;
        wq(3);
        chk("R2", "strap held after reset", cfg_out[7:0], exp_byte(0));
        cpu_stop = 1'b1;
        #1;
        chk("R2", "stop pin live high", cfg_out[7:0], exp_byte(0));
        cpu_stop = 1'b0;
        #1;
        chk("R2", "stop pin live low", cfg_out[7:0], exp_byte(0));

        for (int v = 0; v < NV; v++) run_xfer(VEC[v]);

        // R10: repeated START inside a data byte
        bus_start;
        send_chk(8'hD2, 1'b1, "R10");
        send_chk(8'h00, 1'b1, "R10");
        send_chk(8'h03, 1'b1, "R10");
        send_chk(8'h5A, 1'b1, "R10");
        model_write(0, 8'h5A);
        send_bits(8'hFF, 4);
        bus_start;
        bus_stop;
        wq(Q);
        check_regs("R10");

        // R10: STOP inside a data byte
        bus_start;
        send_chk(8'hD2, 1'b1, "R10");
        send_chk(8'h00, 1'b1, "R10");
        send_chk(8'h02, 1'b1, "R10");
        send_bits(8'h00, 5);
        bus_stop;
        wq(Q);
        check_regs("R10");

        // R10: recovery after aborts
        run_xfer({8'd10, 8'hD2, 8'h00, 8'h02, 8'h02, 8'h24, 8'h42});

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule